// File: doc/BRIEF.md
# Audio Mute/Unmute Sequencer

This block is the control state machine that decides whether a stereo line output is silent or playing. It watches four inputs: a flag saying the master-clock to frame-rate ratio is valid, a flag saying the bit clock is present, an active-low mute pin, and a strobe that pulses once per audio sample. From these it drives an enable for the line-driver stage and an 8-bit digital attenuation code. It also reports whether it is resting in the mute state and whether a first unmute has ever completed.

After reset the output is silent. When the three unmute conditions are all true, the driver stage is enabled and a soft analog unmute is timed in sample strobes. The first soft unmute after reset takes a long, parameterised count. Every later one takes a shorter count. The attenuation code then ramps from full mute to full scale, one 0.5 dB step per sample. If the mute pin drops, the code ramps back up to full mute before the driver is switched off. If either clock condition is lost, the output mutes at once from any state.

Top module: `audio_mute_seq`

## Requirements
- R1: After reset, state_mute is 1, driver_en is 0, vol_code is 255 and unmute_done is 0.
- R2: Leaving the mute state requires ratio_ok, bclk_present and mute_n to be 1 together. On the clock edge that samples all three high in the mute state, driver_en becomes 1 and state_mute becomes 0, while vol_code stays at 255.
- R3: The first soft unmute after reset lasts FIRST_FRAMES frame strobes. unmute_done becomes 1 on the edge that takes the last of those strobes, and vol_code stays 255 until then.
- R4: Every later soft unmute lasts LATER_FRAMES frame strobes before the volume ramp starts.
- R5: During the ramp up, vol_code (255 = full mute, 0 = full scale, 0.5 dB per code) decreases by exactly one on each frame strobe until it reaches 0. The 256th strobe of the ramp enters normal play. Without a strobe the code does not change.
- R6: When mute_n goes low during the ramp up or during normal play, vol_code increases by one per strobe up to 255. The next strobe after that clears driver_en and sets state_mute.
- R7: If ratio_ok or bclk_present goes low while the driver is enabled, then on the next edge driver_en is 0, state_mute is 1 and vol_code is 255, and the block waits in mute.
- R8: In normal play, driver_en stays 1 and vol_code stays 0 for as long as all three conditions hold.
- R9: unmute_done is cleared only by reset. It stays 1 through any later mute.
- R10: If mute_n goes low during a soft unmute, the next edge returns the block to mute with driver_en 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_ok | input | 1 | Master-clock/frame ratio is valid |
| bclk_present | input | 1 | Bit clock is detected |
| mute_n | input | 1 | Mute pin, low requests mute |
| frame_stb | input | 1 | One-cycle pulse per audio sample |
| state_mute | output | 1 | Block is resting in the mute state |
| driver_en | output | 1 | Line-driver stage enable |
| vol_code | output | 8 | Attenuation code, 255 = full mute, 0 = full scale |
| unmute_done | output | 1 | First soft unmute has completed since reset |

## Verification
The gate is tried with each of the three conditions missing while the other two hold. This shows that no single condition, and no pair of them, starts an unmute. Unmute lengths are measured both on the first pass after reset and on a second pass, with the limit probed one strobe before and at its end, which tells the long count apart from the short one. Muting is exercised three ways: through the pin from full scale (a step-wise ramp with a trailing disable), through loss of the bit clock partway through a ramp, and through loss of the ratio during play (both instant). A pin-driven abort during a soft unmute and idle cycles with no strobe separate strobe-paced progress from clock-paced progress.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    ST_MUTE    = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RAMP_UP = 3'd2,
    ST_PLAY    = 3'd3,
    ST_RAMP_DN = 3'd4
  } mseq_state_e;

endpackage

// File: rtl/mseq_cond.sv
// Condition qualifier: folds the three unmute conditions into a go flag
// and a clock-loss flag used for the instant-mute path.
module mseq_cond (
  input  logic ratio_ok,
  input  logic bclk_present,
  input  logic mute_n,
  output logic go_ok,
  output logic clk_lost
);

  always_comb begin
    clk_lost = !(ratio_ok && bclk_present);
    go_ok    = !clk_lost && mute_n;
  end

endmodule

// File: rtl/mseq_soft_timer.sv
// Counts frame strobes while the soft unmute runs; clears when idle.
module mseq_soft_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             stb,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    expire = active && stb && (cnt_q == (limit - CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (stb) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mseq_vol_ramp.sv
// Attenuation register: all-ones is full mute, zero is full scale.
module mseq_vol_ramp #(
  parameter int VOL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_mute,
  input  logic             step_louder,
  input  logic             step_softer,
  output logic [VOL_W-1:0] vol,
  output logic             at_full_scale,
  output logic             at_full_mute
);

  localparam logic [VOL_W-1:0] VOL_MUTE = '1;

  logic [VOL_W-1:0] vol_q;

  always_comb begin
    vol           = vol_q;
    at_full_scale = (vol_q == '0);
    at_full_mute  = (vol_q == VOL_MUTE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_q <= VOL_MUTE;
    end else if (force_mute) begin
      vol_q <= VOL_MUTE;
    end else if (step_louder && (vol_q != '0)) begin
      vol_q <= vol_q - VOL_W'(1);
    end else if (step_softer && (vol_q != VOL_MUTE)) begin
      vol_q <= vol_q + VOL_W'(1);
    end
  end

endmodule

// File: rtl/mseq_fsm.sv
// Sequencing state machine with registered driver and status outputs.
module mseq_fsm (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go_ok,
  input  logic                 clk_lost,
  input  logic                 mute_n,
  input  logic                 stb,
  input  logic                 timer_expire,
  input  logic                 vol_at_scale,
  input  logic                 vol_at_mute,
  output logic                 timer_active,
  output logic                 first_done,
  output logic                 vol_force,
  output logic                 vol_louder,
  output logic                 vol_softer,
  output logic                 state_mute,
  output logic                 driver_en
);

  import mseq_pkg::*;

  mseq_state_e st_q, st_d;
  logic        first_q;
  logic        drv_q;
  logic        mute_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_MUTE: begin
        if (go_ok) st_d = ST_SOFT;
      end
      ST_SOFT: begin
        if (clk_lost || !mute_n) st_d = ST_MUTE;
        else if (timer_expire)   st_d = ST_RAMP_UP;
      end
      ST_RAMP_UP: begin
        if (clk_lost)                   st_d = ST_MUTE;
        else if (!mute_n)               st_d = ST_RAMP_DN;
        else if (stb && vol_at_scale)   st_d = ST_PLAY;
      end
      ST_PLAY: begin
        if (clk_lost)     st_d = ST_MUTE;
        else if (!mute_n) st_d = ST_RAMP_DN;
      end
      ST_RAMP_DN: begin
        if (clk_lost)                 st_d = ST_MUTE;
        else if (stb && vol_at_mute)  st_d = ST_MUTE;
      end
      default: st_d = ST_MUTE;
    endcase
  end

  always_comb begin
    timer_active = (st_q == ST_SOFT);
    vol_force    = (st_d == ST_MUTE);
    vol_louder   = (st_q == ST_RAMP_UP) && (st_d == ST_RAMP_UP) && stb;
    vol_softer   = (st_q == ST_RAMP_DN) && (st_d == ST_RAMP_DN) && stb;
    first_done   = first_q;
    state_mute   = mute_q;
    driver_en    = drv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_MUTE;
      first_q <= 1'b0;
      drv_q   <= 1'b0;
      mute_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      drv_q  <= (st_d != ST_MUTE);
      mute_q <= (st_d == ST_MUTE);
      if ((st_q == ST_SOFT) && (st_d == ST_RAMP_UP)) begin
        first_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/audio_mute_seq.sv
// Top level of the mute/unmute sequencer.
module audio_mute_seq #(
  parameter int FIRST_FRAMES = 16368,
  parameter int LATER_FRAMES = 2000,
  parameter int VOL_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ratio_ok,
  input  logic             bclk_present,
  input  logic             mute_n,
  input  logic             frame_stb,
  output logic             state_mute,
  output logic             driver_en,
  output logic [VOL_W-1:0] vol_code,
  output logic             unmute_done
);

  localparam int MAX_FRAMES = (FIRST_FRAMES > LATER_FRAMES) ? FIRST_FRAMES : LATER_FRAMES;
  localparam int CNT_W      = $clog2(MAX_FRAMES + 1);

  logic             go_ok;
  logic             clk_lost;
  logic             timer_active;
  logic             timer_expire;
  logic             first_done;
  logic             vol_force;
  logic             vol_louder;
  logic             vol_softer;
  logic             vol_at_scale;
  logic             vol_at_mute;
  logic [CNT_W-1:0] soft_limit;

  always_comb begin
    soft_limit  = first_done ? CNT_W'(LATER_FRAMES) : CNT_W'(FIRST_FRAMES);
    unmute_done = first_done;
  end

  mseq_cond cond_i (
    .ratio_ok     (ratio_ok),
    .bclk_present (bclk_present),
    .mute_n       (mute_n),
    .go_ok        (go_ok),
    .clk_lost     (clk_lost)
  );

  mseq_soft_timer #(.CNT_W(CNT_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .active (timer_active),
    .stb    (frame_stb),
    .limit  (soft_limit),
    .expire (timer_expire)
  );

  mseq_vol_ramp #(.VOL_W(VOL_W)) ramp_i (
    .clk           (clk),
    .rst           (rst),
    .force_mute    (vol_force),
    .step_louder   (vol_louder),
    .step_softer   (vol_softer),
    .vol           (vol_code),
    .at_full_scale (vol_at_scale),
    .at_full_mute  (vol_at_mute)
  );

  mseq_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .go_ok        (go_ok),
    .clk_lost     (clk_lost),
    .mute_n       (mute_n),
    .stb          (frame_stb),
    .timer_expire (timer_expire),
    .vol_at_scale (vol_at_scale),
    .vol_at_mute  (vol_at_mute),
    .timer_active (timer_active),
    .first_done   (first_done),
    .vol_force    (vol_force),
    .vol_louder   (vol_louder),
    .vol_softer   (vol_softer),
    .state_mute   (state_mute),
    .driver_en    (driver_en)
  );

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int VOL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ratio_ok,
  input logic             bclk_present,
  input logic             mute_n,
  input logic             frame_stb,
  input logic             state_mute,
  input logic             driver_en,
  input logic [VOL_W-1:0] vol_code,
  input logic             unmute_done
);

  localparam logic [VOL_W-1:0] FULL_MUTE = '1;

  assert_mute_xor_drive_R1: assert property (@(posedge clk) disable iff (rst)
    state_mute != driver_en);

  assert_gate_all_three_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(driver_en) |-> $past(ratio_ok && bclk_present && mute_n));

  assert_first_done_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(unmute_done) |-> $past(frame_stb));

  assert_vol_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    driver_en |=> ((vol_code == $past(vol_code)) ||
                   (vol_code == $past(vol_code) + VOL_W'(1)) ||
                   (vol_code == $past(vol_code) - VOL_W'(1)) ||
                   (vol_code == FULL_MUTE)));

  assert_vol_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && ratio_ok && bclk_present) |=> $stable(vol_code));

  assert_instant_mute_R7: assert property (@(posedge clk) disable iff (rst)
    (driver_en && !(ratio_ok && bclk_present)) |=>
      (state_mute && !driver_en && vol_code == FULL_MUTE));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    unmute_done |=> unmute_done);

endmodule

bind audio_mute_seq mseq_checker #(.VOL_W(VOL_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .ratio_ok     (ratio_ok),
  .bclk_present (bclk_present),
  .mute_n       (mute_n),
  .frame_stb    (frame_stb),
  .state_mute   (state_mute),
  .driver_en    (driver_en),
  .vol_code     (vol_code),
  .unmute_done  (unmute_done)
);

// File: tb/audio_mute_seq_tb_top.sv
`timescale 1ns/1ps
module audio_mute_seq_tb_top;

  localparam int FIRST = 40;
  localparam int LATER = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ratio_ok = 1'b0;
  logic       bclk_present = 1'b0;
  logic       mute_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic       state_mute;
  logic       driver_en;
  logic [7:0] vol_code;
  logic       unmute_done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  audio_mute_seq #(.FIRST_FRAMES(FIRST), .LATER_FRAMES(LATER), .VOL_W(8)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .ratio_ok     (ratio_ok),
    .bclk_present (bclk_present),
    .mute_n       (mute_n),
    .frame_stb    (frame_stb),
    .state_mute   (state_mute),
    .driver_en    (driver_en),
    .vol_code     (vol_code),
    .unmute_done  (unmute_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_stb = 1'b1;
      tick();
      frame_stb = 1'b0;
      tick();
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit m, input bit d, input int v);
    check(state_mute == m, {req, " state_mute"}, state_mute, m);
    check(driver_en == d,  {req, " driver_en"},  driver_en, d);
    check(vol_code == v,   {req, " vol_code"},   vol_code, v);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk_out("R1", 1'b1, 1'b0, 255);
    check(unmute_done == 1'b0, "R1 unmute_done", unmute_done, 0);
  endtask

  task automatic t_gate();
    ratio_ok = 1; bclk_present = 1; mute_n = 0;
    frames(3);
    chk_out("R2 mute pin low", 1'b1, 1'b0, 255);
    ratio_ok = 0; mute_n = 1;
    frames(3);
    chk_out("R2 ratio bad", 1'b1, 1'b0, 255);
    ratio_ok = 1; bclk_present = 0;
    frames(3);
    chk_out("R2 no bclk", 1'b1, 1'b0, 255);
  endtask

  task automatic t_first_unmute();
    bclk_present = 1;
    tick();
    chk_out("R2 start", 1'b0, 1'b1, 255);
    frames(FIRST - 1);
    check(unmute_done == 1'b0, "R3 before end", unmute_done, 0);
    check(vol_code == 255, "R3 vol held", vol_code, 255);
    frames(1);
    check(unmute_done == 1'b1, "R3 at end", unmute_done, 1);
    check(vol_code == 255, "R5 ramp start", vol_code, 255);
    tick(); tick(); tick();
    check(vol_code == 255, "R5 no strobe", vol_code, 255);
    frames(100);
    check(vol_code == 155, "R5 mid ramp", vol_code, 155);
    frames(155);
    check(vol_code == 0, "R5 full scale", vol_code, 0);
    frames(1);
    for (int i = 0; i < 20; i++) tick();
    chk_out("R8 play", 1'b0, 1'b1, 0);
  endtask

  task automatic t_pin_mute();
    mute_n = 0;
    tick();
    chk_out("R6 entry", 1'b0, 1'b1, 0);
    frames(1);
    check(vol_code == 1, "R6 first step", vol_code, 1);
    frames(254);
    chk_out("R6 at mute code", 1'b0, 1'b1, 255);
    frames(1);
    chk_out("R6 driver off", 1'b1, 1'b0, 255);
    check(unmute_done == 1'b1, "R9 after pin mute", unmute_done, 1);
  endtask

  task automatic t_second_unmute();
    mute_n = 1;
    tick();
    chk_out("R4 start", 1'b0, 1'b1, 255);
    frames(LATER);
    check(vol_code == 255, "R4 at limit", vol_code, 255);
    frames(1);
    check(vol_code == 254, "R4 ramp begun", vol_code, 254);
  endtask

  task automatic t_instant_bclk();
    frames(50);
    check(vol_code == 204, "R5 second ramp", vol_code, 204);
    bclk_present = 0;
    tick();
    chk_out("R7 bclk lost", 1'b1, 1'b0, 255);
    check(unmute_done == 1'b1, "R9 after instant", unmute_done, 1);
    frames(3);
    chk_out("R7 waits", 1'b1, 1'b0, 255);
  endtask

  task automatic t_instant_ratio();
    bclk_present = 1;
    tick();
    frames(LATER + 256);
    chk_out("R8 play again", 1'b0, 1'b1, 0);
    ratio_ok = 0;
    tick();
    chk_out("R7 ratio lost", 1'b1, 1'b0, 255);
  endtask

  task automatic t_soft_abort();
    ratio_ok = 1;
    tick();
    chk_out("R10 soft start", 1'b0, 1'b1, 255);
    frames(5);
    mute_n = 0;
    tick();
    chk_out("R10 abort", 1'b1, 1'b0, 255);
  endtask

  task automatic t_reset_clears();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    check(unmute_done == 1'b0, "R9 reset clears", unmute_done, 0);
    mute_n = 1;
    tick();
    frames(LATER);
    check(unmute_done == 1'b0, "R3 long count again", unmute_done, 0);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_first_unmute();
    t_pin_mute();
    t_second_unmute();
    t_instant_bclk();
    t_instant_ratio();
    t_soft_abort();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule